// File: doc/BRIEF.md
# Multi-Socket Indexed Register Port

This block is the host-facing register access front end of a card-socket bridge. The host sees two byte-wide locations. Port location 0 holds an index that selects one byte of a flat register space. Port location 1 is a data window onto the byte that the index selects. The host first writes the index and then reads or writes the data window as often as it needs. The index keeps its value until the host writes it again.

The flat space is split into one bank per socket, and each bank is 64 index values wide. The top two index bits pick the socket and the low six bits pick the byte inside its bank. A two-bit configuration field sets how many sockets are live: one, two or four. Only the first few offsets of each bank hold storage, and the number of them is a parameter. A location in an inactive socket, or at an offset with no storage behind it, reads as zero, and a write to it is dropped. Reads of either port location are combinational. Writes take effect on the clock edge where the write strobe is high.

Top module: `sock_index_port`

## Requirements
- R1: A write to port location 0 loads the 8-bit index on that clock edge. The index is unchanged by any other access. A read of location 0 returns the current index.
- R2: A write to port location 1 stores the data byte into the location that the index selects. A later read of location 1 at the same index returns that byte in the same cycle it is addressed.
- R3: Index bits [7:6] select the socket (0 to 3) and bits [5:0] select the offset within that socket's bank. Each socket starts at index socket*0x40, and the same offset in different sockets holds independent values.
- R4: The configuration field `sock_cfg` (bits [2:1] of the bridge configuration byte) sets the live socket count: 2'b00 gives sockets 0 and 1, 2'b01 gives socket 0 only, and 2'b10 or 2'b11 gives all four.
- R5: While a socket is inactive, data reads at its indices return 0x00 and data writes to it leave its stored bytes unchanged. The unchanged bytes are visible again once the socket is made active.
- R6: Offsets at or above IMPL_REGS in any bank read as 0x00 and ignore writes. Offset IMPL_REGS-1 is fully usable.
- R7: A 16-bit value is held as two consecutive indices, with the low byte at the lower index. The two bytes are written and read back independently without disturbing each other.
- R8: Reset (rst_n low) clears the index to 0x00 and every stored byte to 0x00.
- R9: A read-modify-write works with no side effects. The host reads the data window, rewrites the same index, then writes the modified byte to the data window, and the final byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | Port select: 0 is the index port, 1 is the data window |
| host_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Combinational read data for the selected port location |
| sock_cfg | input | 2 | Live socket count select (configuration byte bits [2:1]) |

## Verification
The bench builds the block with its default IMPL_REGS of 16. With that value, offsets 0x10 through 0x3F of every bank have no storage, so both the last usable offset (0x0F) and the first dropped one (0x10) can be reached from the host. All four socket banks are built, and the bench steps `sock_cfg` through all four encodings. This puts the same stored bytes inside and outside the active range, so it shows both the zero readback and the dropped writes. A mid-run reset after the banks are filled shows that every stored byte and the index return to zero.

// File: rtl/sip_pkg.sv
package sip_pkg;
    localparam int SOCK_MAX = 4;
    localparam int SOCK_W   = $clog2(SOCK_MAX);
    localparam int OFF_W    = 6;
    localparam int IDX_W    = SOCK_W + OFF_W;
    localparam int BYTE_W   = 8;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } port_state_t;

    // Socket-count field to live-socket mask
    function automatic logic [SOCK_MAX-1:0] cfg_to_mask(input logic [1:0] cfg);
        logic [SOCK_MAX-1:0] m;
        case (cfg)
            2'b00:   m = 4'b0011;
            2'b01:   m = 4'b0001;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sip_decode.sv
module sip_decode
    import sip_pkg::*;
#(
    parameter int IMPL_REGS = 16
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic [1:0]          sock_cfg,
    output logic [SOCK_W-1:0]   sock,
    output logic [OFF_W-1:0]    off,
    output logic [SOCK_MAX-1:0] live_mask,
    output logic                sock_active,
    output logic                off_impl
);
    always_comb begin
        sock        = idx[IDX_W-1 -: SOCK_W];
        off         = idx[OFF_W-1:0];
        live_mask   = cfg_to_mask(sock_cfg);
        sock_active = live_mask[sock];
        off_impl    = ({1'b0, off} < (OFF_W+1)'(IMPL_REGS));
    end
endmodule

// File: rtl/sip_bank.sv
module sip_bank
    import sip_pkg::*;
#(
    parameter int IMPL_REGS = 16,
    localparam int REG_W    = (IMPL_REGS > 1) ? $clog2(IMPL_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [REG_W-1:0]  rd_reg,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] regs_d [IMPL_REGS];
    logic [BYTE_W-1:0] regs_q [IMPL_REGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_reg] = wr_data;
        rd_data = regs_q[rd_reg];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IMPL_REGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R2: an accepted write is stored at the addressed byte
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_reg)] == $past(wr_data));
endmodule

// File: rtl/sock_index_port.sv
module sock_index_port
    import sip_pkg::*;
#(
    parameter int IMPL_REGS = 16,
    localparam int REG_W    = (IMPL_REGS > 1) ? $clog2(IMPL_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [1:0]        sock_cfg
);
    port_state_t st_d, st_q;

    logic [SOCK_W-1:0]   sock;
    logic [OFF_W-1:0]    off;
    logic [SOCK_MAX-1:0] live_mask;
    logic                sock_active;
    logic                off_impl;
    logic                data_hit;
    logic [BYTE_W-1:0]   bank_rd [SOCK_MAX];

    sip_decode #(.IMPL_REGS(IMPL_REGS)) u_decode (
        .idx        (st_q.idx),
        .sock_cfg   (sock_cfg),
        .sock       (sock),
        .off        (off),
        .live_mask  (live_mask),
        .sock_active(sock_active),
        .off_impl   (off_impl)
    );

    assign data_hit = sock_active && off_impl;

    for (genvar g = 0; g < SOCK_MAX; g++) begin : g_bank
        sip_bank #(.IMPL_REGS(IMPL_REGS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (host_wr && host_addr && data_hit && (sock == SOCK_W'(g))),
            .wr_reg (off[REG_W-1:0]),
            .wr_data(host_wdata),
            .rd_reg (off[REG_W-1:0]),
            .rd_data(bank_rd[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (host_wr && !host_addr) st_d.idx = host_wdata;
        if (!host_addr)    host_rdata = st_q.idx;
        else if (data_hit) host_rdata = bank_rd[sock];
        else               host_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: index port write loads the index
    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_addr) |=> (host_rdata == $past(host_wdata) || host_addr));
    // R1: index holds across every other access
    a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_addr) |=> $stable(st_q.idx));
    // R4: live mask is one of the three legal shapes
    a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (live_mask == 4'b0001) || (live_mask == 4'b0011) || (live_mask == 4'b1111));
    // R5: inactive socket data reads are zero
    a_r5_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr && !sock_active) |-> host_rdata == '0);
    // R6: unimplemented offsets read as zero
    a_r6_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr && !off_impl) |-> host_rdata == '0);
endmodule

// File: tb/sock_index_port_tb.sv
module sock_index_port_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       host_addr = 0;
    logic       host_wr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic [1:0] sock_cfg = 2'b10;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    sock_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sock_cfg(sock_cfg)
    );

    // {req, kind, cfg byte, value}; kind 0 idx write, 1 data write, 2 data check, 3 idx check
    localparam int NV = 40;
    localparam logic [21:0] VEC [NV] = '{
        // R2 basic store and readback
        {4'd2, 2'd0, 8'h04, 8'h00}, {4'd2, 2'd1, 8'h04, 8'h11}, {4'd2, 2'd2, 8'h04, 8'h11},
        // R3 socket banks at 0x40 stride
        {4'd3, 2'd0, 8'h04, 8'h40}, {4'd3, 2'd1, 8'h04, 8'h22}, {4'd3, 2'd2, 8'h04, 8'h22},
        {4'd3, 2'd0, 8'h04, 8'h80}, {4'd3, 2'd1, 8'h04, 8'h33}, {4'd3, 2'd2, 8'h04, 8'h33},
        {4'd3, 2'd0, 8'h04, 8'hC0}, {4'd3, 2'd1, 8'h04, 8'h44}, {4'd3, 2'd2, 8'h04, 8'h44},
        // R1 index readback
        {4'd1, 2'd3, 8'h04, 8'hC0},
        {4'd3, 2'd0, 8'h04, 8'h00}, {4'd3, 2'd2, 8'h04, 8'h11},
        // R7 16-bit pair
        {4'd7, 2'd0, 8'h04, 8'h05}, {4'd7, 2'd1, 8'h04, 8'hA5}, {4'd7, 2'd0, 8'h04, 8'h06},
        {4'd7, 2'd1, 8'h04, 8'h5A}, {4'd7, 2'd0, 8'h04, 8'h05}, {4'd7, 2'd2, 8'h04, 8'hA5},
        {4'd7, 2'd0, 8'h04, 8'h06}, {4'd7, 2'd2, 8'h04, 8'h5A},
        // R4 / R5 socket count and inactive banks
        {4'd4, 2'd0, 8'h02, 8'h40}, {4'd5, 2'd2, 8'h02, 8'h00}, {4'd5, 2'd1, 8'h02, 8'h99},
        {4'd5, 2'd2, 8'h04, 8'h22}, {4'd4, 2'd2, 8'h00, 8'h22}, {4'd4, 2'd0, 8'h00, 8'h80},
        {4'd4, 2'd2, 8'h00, 8'h00}, {4'd4, 2'd0, 8'h06, 8'hC0}, {4'd4, 2'd2, 8'h06, 8'h44},
        // R6 unimplemented offsets and last usable offset
        {4'd6, 2'd0, 8'h04, 8'h10}, {4'd6, 2'd1, 8'h04, 8'h77}, {4'd6, 2'd2, 8'h04, 8'h00},
        {4'd6, 2'd0, 8'h04, 8'h50}, {4'd6, 2'd2, 8'h04, 8'h00}, {4'd6, 2'd0, 8'h04, 8'h0F},
        {4'd6, 2'd1, 8'h04, 8'hE1}, {4'd6, 2'd2, 8'h04, 8'hE1}
    };

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wr = 1; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic chk(input logic a, input logic [7:0] exp, input int req);
        @(negedge clk);
        host_addr = a;
        #1;
        n_chk++;
        if (host_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d: port %0d got %02h expected %02h", req, a, host_rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(0, 8'h00, 8);
        rst_n = 1;
        chk(0, 8'h00, 8);
        chk(1, 8'h00, 8);
        for (int i = 0; i < NV; i++) begin
            sock_cfg = VEC[i][10:9];
            case (VEC[i][17:16])
                2'd0: wr(0, VEC[i][7:0]);
                2'd1: wr(1, VEC[i][7:0]);
                2'd2: chk(1, VEC[i][7:0], int'(VEC[i][21:18]));
                default: chk(0, VEC[i][7:0], int'(VEC[i][21:18]));
            endcase
        end
        sock_cfg = 2'b10;
        // R9 read-modify-write on index 0x00 holding 0x11
        wr(0, 8'h00);
        chk(1, 8'h11, 9);
        wr(0, 8'h00);
        wr(1, 8'h11 | 8'h80);
        chk(1, 8'h91, 9);
        // R1 index unchanged by data writes
        wr(1, 8'h92);
        wr(1, 8'h93);
        chk(0, 8'h00, 1);
        chk(1, 8'h93, 1);
        // R8 reset mid-run clears everything
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        chk(0, 8'h00, 8);
        chk(1, 8'h00, 8);
        wr(0, 8'h40); chk(1, 8'h00, 8);
        wr(0, 8'hC0); chk(1, 8'h00, 8);
        wr(0, 8'h0F); chk(1, 8'h00, 8);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule